// File: doc/BRIEF.md
# Reset-Cause Status Register with Guarded Debug-Port Disable

This block is an 8-bit control and status register for a microcontroller-style system. Five flags record which reset source fired: power-on, external pin, brown-out, watchdog and debug-port reset. Software reads the flags through the read port and clears them by writing zeros.

The top bit is a debug-port disable control. It is combined with a fuse input to produce the debug interface enable. So that a stray store cannot flip the bit, it accepts a new value only when software writes the same value twice within a short window of cycles. Flag writes need no such sequence and act on the first write.

The reset pulses are inputs from the reset generator. The block only records them and does not generate them.

Top module: `rst_cause_ctl`

## Requirements
- R1: After `rst_n` is released, `rd_data` reads 0x00, `dbg_disable` is 0 and `dbg_if_en` equals `fuse_dbg_en`.
- R2: `dbg_if_en` is 1 exactly when `fuse_dbg_en` is 1 and the disable bit is 0. The disable bit reads back at `rd_data[7]`.
- R3: A single write to bit 7 with no matching follow-up leaves the disable bit unchanged.
- R4: The disable bit takes a value v when a write with bit 7 = v is followed by a second write with bit 7 = v. The second write must come 1 to 4 cycles after the first. The new value is visible in the cycle after the second write.
- R5: A follow-up write with a different bit-7 value, or one arriving 5 or more cycles after the first, does not change the bit. That later write opens a new window, and a matching write inside the new window then commits.
- R6: A `por_evt` pulse sets the power-on flag (bit 0) and clears bits 1 to 4, unless another source fires in the same cycle.
- R7: `ext_evt`, `bod_evt`, `wdt_evt` and `dbg_rst_evt` each set only their own flag: bit 1, bit 2, bit 3 and bit 4 respectively. All other flags keep their values.
- R8: Writing 0 to a flag bit (bits 4 to 0) clears it on the first write. Writing 1 has no effect. Bits 6 and 5 always read 0.
- R9: When a source event and a software clear of the same flag fall in the same cycle, the flag ends up set. A source event in the same cycle as `por_evt` also leaves its flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low register reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 8 | Write data |
| por_evt | input | 1 | Power-on reset pulse |
| ext_evt | input | 1 | External reset pulse |
| bod_evt | input | 1 | Brown-out reset pulse |
| wdt_evt | input | 1 | Watchdog reset pulse |
| dbg_rst_evt | input | 1 | Debug-port reset pulse |
| fuse_dbg_en | input | 1 | Fuse: debug port permitted |
| rd_data | output | 8 | Register read value |
| dbg_disable | output | 1 | Current disable bit |
| dbg_if_en | output | 1 | Debug interface enable |

## Verification
Two functions can fall in the same cycle: a reset source setting a flag, and a software write clearing it, or a power-on pulse clearing it. The bench fires each source together with a write of 0x00 and the expected result is that only the firing flag survives. It also fires a watchdog pulse together with a power-on pulse and expects both flags set. The clear path is also swept exhaustively over every flag pattern against every write pattern, with the expected value computed as a bitwise AND.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  localparam int REG_W     = 8;
  localparam int NUM_FLAGS = 5;
  localparam int DIS_BIT   = 7;
  localparam int POR_IDX   = 0;
  localparam int WINDOW    = 4;
endpackage

// File: rtl/rcs_timed_bit.sv
module rcs_timed_bit #(
  parameter int WINDOW = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_val,
  output logic bit_o
);
  localparam int CW = $clog2(WINDOW + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(WINDOW);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          pend_q, pend_d;
  logic          bit_q, bit_d;
  logic          win_open, commit, upd;

  always_comb begin
    win_open = (cnt_q != '0);
    commit   = wr_en && win_open && (wr_val == pend_q);
    cnt_d    = cnt_q;
    pend_d   = pend_q;
    bit_d    = bit_q;
    if (commit) begin
      cnt_d = '0;
      bit_d = pend_q;
    end else if (wr_en) begin
      cnt_d  = CNT_LOAD;
      pend_d = wr_val;
    end else if (win_open) begin
      cnt_d = cnt_q - CW'(1);
    end
    upd = wr_en || win_open;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
      bit_q  <= 1'b0;
    end else if (upd) begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
      bit_q  <= bit_d;
    end
  end

  assign bit_o = bit_q;

  AST_LONE_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && cnt_q != '0) |=> $stable(bit_q)); // R3
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LOAD); // R4
  AST_MATCH_COMMITS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cnt_q != '0 && wr_val == pend_q) |=> (bit_q == $past(wr_val) && cnt_q == '0)); // R4
  AST_REOPEN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (cnt_q == '0 || wr_val != pend_q)) |=> (cnt_q == CNT_LOAD && pend_q == $past(wr_val))); // R5
endmodule

// File: rtl/rcs_flag_bank.sv
module rcs_flag_bank #(
  parameter int N       = 5,
  parameter int POR_IDX = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_evt,
  input  logic [N-1:0] clr_req,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] flag_q, flag_d, flag_en;

  for (genvar i = 0; i < N; i++) begin : g_flag
    if (i == POR_IDX) begin : g_por
      always_comb begin
        flag_en[i] = src_evt[i] || clr_req[i];
        flag_d[i]  = src_evt[i];
      end
    end else begin : g_src
      always_comb begin
        flag_en[i] = src_evt[i] || src_evt[POR_IDX] || clr_req[i];
        flag_d[i]  = src_evt[i];
      end
      AST_POR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (src_evt[POR_IDX] && !src_evt[i]) |=> !flag_q[i]); // R6
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_q[i] <= 1'b0;
      else if (flag_en[i]) flag_q[i] <= flag_d[i];
    end

    AST_SRC_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      src_evt[i] |=> flag_q[i]); // R9
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req[i] && !src_evt[i]) |=> !flag_q[i]); // R8
    AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!src_evt[i] && !src_evt[POR_IDX] && !clr_req[i]) |=> $stable(flag_q[i])); // R7
  end

  assign flags_o = flag_q;
endmodule

// File: rtl/rst_cause_ctl.sv
module rst_cause_ctl
  import rcs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             por_evt,
  input  logic             ext_evt,
  input  logic             bod_evt,
  input  logic             wdt_evt,
  input  logic             dbg_rst_evt,
  input  logic             fuse_dbg_en,
  output logic [REG_W-1:0] rd_data,
  output logic             dbg_disable,
  output logic             dbg_if_en
);
  logic [NUM_FLAGS-1:0] src_vec, clr_vec, flags;
  logic                 dis_bit;

  always_comb begin
    src_vec = {dbg_rst_evt, wdt_evt, bod_evt, ext_evt, por_evt};
    clr_vec = {NUM_FLAGS{wr_en}} & ~wr_data[NUM_FLAGS-1:0];
  end

  rcs_flag_bank #(.N(NUM_FLAGS), .POR_IDX(POR_IDX)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_evt (src_vec),
    .clr_req (clr_vec),
    .flags_o (flags)
  );

  rcs_timed_bit #(.WINDOW(WINDOW)) u_dis (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_val (wr_data[DIS_BIT]),
    .bit_o  (dis_bit)
  );

  always_comb begin
    rd_data                  = '0;
    rd_data[NUM_FLAGS-1:0]   = flags;
    rd_data[DIS_BIT]         = dis_bit;
    dbg_disable              = dis_bit;
    dbg_if_en                = fuse_dbg_en && !dis_bit;
  end

  AST_DIS_BLOCKS_IF: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[DIS_BIT] |-> !dbg_if_en); // R2
endmodule

// File: tb/sim_rst_cause_ctl.sv
module sim_rst_cause_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [4:0] evt = 5'b0;
  logic       fuse = 1'b1;
  logic [7:0] rd_data;
  logic       dbg_disable, dbg_if_en;
  int         checks = 0;
  int         errors = 0;
  logic       model_dis = 1'b0;

  always #10 clk = ~clk;

  rst_cause_ctl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .por_evt(evt[0]), .ext_evt(evt[1]), .bod_evt(evt[2]), .wdt_evt(evt[3]),
    .dbg_rst_evt(evt[4]), .fuse_dbg_en(fuse),
    .rd_data(rd_data), .dbg_disable(dbg_disable), .dbg_if_en(dbg_if_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic pulse(input logic [4:0] e);
    evt = e;
    @(negedge clk);
    evt = 5'b0;
  endtask

  // disable bit value v, flag bits written as ones (no effect on flags)
  function automatic logic [7:0] dv(input logic v);
    return {v, 7'h1F};
  endfunction

  task automatic set_dis(input logic v);
    wr(dv(v)); wr(dv(v)); cyc(6);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    chk("R1 rd_data", rd_data, 8'h00);
    chk("R1 disable", dbg_disable, 0);
    chk("R1 if_en", dbg_if_en, 1);

    // R2: fuse x disable sweep
    for (int s = 0; s < 2; s++) begin
      set_dis(s[0]);
      for (int f = 0; f < 2; f++) begin
        fuse = f[0];
        cyc(1);
        chk("R2 if_en", dbg_if_en, f[0] & ~s[0]);
        chk("R2 readback", rd_data[7], s[0]);
      end
    end
    fuse = 1'b1;

    // R3/R4/R5: gap sweep
    for (int s = 0; s < 2; s++) begin
      for (int v = 0; v < 2; v++) begin
        for (int k = 1; k <= 7; k++) begin
          set_dis(s[0]);
          wr(dv(v[0]));
          chk("R3 single write", dbg_disable, s[0]);
          if (k > 1) cyc(k - 1);
          wr(dv(v[0]));
          model_dis = (k <= 4) ? v[0] : s[0];
          chk(k <= 4 ? "R4 double write" : "R5 late write", dbg_disable, model_dis);
          cyc(6);
        end
      end
    end

    // R5: mismatching writes reopen window
    set_dis(1'b0);
    wr(dv(1)); wr(dv(0)); wr(dv(1));
    chk("R5 mismatch chain", dbg_disable, 0);
    wr(dv(1));
    chk("R5 new window commits", dbg_disable, 1);
    cyc(6);
    set_dis(1'b0);
    wr(dv(1)); cyc(5); wr(dv(1));
    chk("R5 late opens window", dbg_disable, 0);
    wr(dv(1));
    chk("R5 late then match", dbg_disable, 1);
    cyc(6);
    set_dis(1'b0);

    // R6/R7/R8: every flag pattern against every write pattern
    for (int m = 0; m < 16; m++) begin
      for (int w = 0; w < 32; w++) begin
        pulse(5'b00001);
        chk("R6 por", rd_data, 8'h01);
        pulse({m[3:0], 1'b0});
        chk("R7 sources", rd_data, {3'b000, m[3:0], 1'b1});
        wr({1'b0, 2'b11, w[4:0]});
        chk("R8 clear", rd_data, {3'b000, ({m[3:0], 1'b1} & w[4:0])});
      end
    end

    // R7: each source alone keeps others
    pulse(5'b00001);
    for (int i = 1; i < 5; i++) begin
      pulse(5'(1 << i));
      chk("R7 one source", rd_data, 8'((2 << i) - 1));
    end
    pulse(5'b00001);
    chk("R6 por clears all", rd_data, 8'h01);

    // R9: set beats same-cycle clear
    for (int i = 0; i < 5; i++) begin
      pulse(5'b11110);
      evt = 5'(1 << i); wr_en = 1'b1; wr_data = 8'h00;
      @(negedge clk);
      evt = 5'b0; wr_en = 1'b0;
      chk("R9 set beats clear", rd_data, 8'(1 << i));
    end
    pulse(5'b11110);
    pulse(5'b01001);
    chk("R9 por with watchdog", rd_data, 8'h09);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule